// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block keeps the interrupt status of a real-time clock running in calendar mode, and it drives one interrupt request line. A free-running prescaler counter sits inside the block. When bit n+2 of the prescaler rises from 0 to 1, the block sets periodic flag n, for each of the eight periodic flags. Four event strobes come in from logic outside the block: counter overflow, tamper detection, and two alarm compare matches. Each strobe sets its own flag.

Software uses a small register bus. It reads the 16-bit flag word and clears flags by writing ones to them. It turns individual interrupt enables on and off through two write addresses, one that sets enables and one that clears them. The interrupt request is high while any flag that is set also has its enable set.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the flag word, the enable word and `irq` are all 0.
- R2: The flag word is read at bus address 0, and its bit positions are fixed. Bit 15 is overflow and bit 14 is tamper. Bit 9 is alarm 1 and bit 8 is alarm 0. Bits 7..0 are periodic flags 7..0. Address 3 reads as 0 and ignores writes.
- R3: Bits 13..10 of the flag word and of the enable word always read 0, and writes to them have no effect.
- R4: A write to address 0 clears every implemented flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: An `ovf_evt` or `alarm_evt[n]` strobe that is high at a clock edge sets its flag. The flag is visible after that edge, which is one cycle after the condition.
- R6: A `tamper_evt` strobe that is high at a clock edge sets bit 14 after that edge.
- R7: The prescaler is 0 after reset and counts up by one each clock, wrapping at 2^PRESC_W. Periodic flag n is set on the edge that follows the cycle in which prescaler bit n+2 went from 0 to 1.
- R8: A hardware set and a software clear that hit the same flag in the same cycle leave the flag set.
- R9: A write to address 1 sets the enables whose data bits are 1. A write to address 2 clears the enables whose data bits are 1. Data bits that are 0 leave their enables unchanged. Reads at address 1 or 2 return the enable word.
- R10: `irq` is 1 exactly when some flag and its matching enable are both 1, judged on the registered state of the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address: 0 flags, 1 enable set, 2 enable clear, 3 none |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ovf_evt | input | 1 | Counter overflow strobe |
| tamper_evt | input | 1 | Tamper detection strobe |
| alarm_evt | input | 2 | Alarm compare match strobes, bit n for alarm n |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default `PRESC_W` of 10. With that width the prescaler wraps every 1024 cycles, so a run of a few thousand cycles shows every periodic bit rising, including bit 9 for periodic flag 7. It also shows the wrap from all ones back to zero, which must set no flag. Event strobes and clears are placed both apart from and on top of the periodic sets, so the bench also sees collisions between set and clear.

// File: rtl/rtc_irq_pkg.sv
// Package: constants shared by the real-time clock interrupt flag controller.
// It holds the flag bit positions, the mask of implemented bits and the bus addresses.
package rtc_irq_pkg;
    localparam int FLAG_W     = 16;
    localparam int BIT_OVF    = 15;
    localparam int BIT_TAMPER = 14;
    localparam int BIT_ALARM0 = 8;
    localparam int NUM_ALARM  = 2;
    localparam int NUM_PER    = 8;
    localparam int PER_OFS    = 2;
    localparam logic [FLAG_W-1:0] IMPL_MASK = 16'hC3FF;

    typedef enum logic [1:0] {
        ADDR_FLAGS  = 2'd0,
        ADDR_EN_SET = 2'd1,
        ADDR_EN_CLR = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/rtc_prescaler.sv
// Module: free-running prescaler counter.
// It is cleared by a synchronous active-low reset and then adds one each clock, wrapping at 2^W.
module rtc_prescaler #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    // Count one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/rtc_edge_detect.sv
// Module: rising-edge detector for prescaler bits OFS..OFS+NUM-1.
// It registers each watched bit and flags a 0-to-1 change against the previous cycle.
// It assumes W >= OFS+NUM.
module rtc_edge_detect #(
    parameter int W   = 10,
    parameter int NUM = 8,
    parameter int OFS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   presc,
    output logic [NUM-1:0] rise
);
    logic [NUM-1:0] prev_q;

    // Hold the watched bits as they were one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= presc[OFS +: NUM];
    end

    for (genvar i = 0; i < NUM; i++) begin : g_rise
        assign rise[i] = presc[OFS+i] & ~prev_q[i];
    end
endmodule

// File: rtl/rtc_flag_bank.sv
// Module: bank of set/clear bits. A set wins over a clear in the same cycle.
// Bits that are 0 in MASK are not stored and read as constant 0.
module rtc_flag_bank #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            // One stored bit: set has priority, then clear, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n)      q[i] <= 1'b0;
                else if (set[i]) q[i] <= 1'b1;
                else if (clr[i]) q[i] <= 1'b0;
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: top of the real-time clock interrupt flag controller.
// It builds the set vector from the event strobes and the prescaler edges, applies
// write-one-to-clear from the bus, keeps the per-flag enables and drives one
// interrupt request. It assumes PRESC_W >= PER_OFS + NUM_PER.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int PRESC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [FLAG_W-1:0] bus_wdata,
    output logic [FLAG_W-1:0] bus_rdata,
    input  logic              ovf_evt,
    input  logic              tamper_evt,
    input  logic [NUM_ALARM-1:0] alarm_evt,
    output logic              irq
);
    localparam int TOP_BIT = PER_OFS + NUM_PER;

    if (PRESC_W < TOP_BIT) begin : g_bad_width
        $error("PRESC_W too narrow for the periodic flags");
    end

    logic [PRESC_W-1:0] presc;
    logic [NUM_PER-1:0] per_rise;
    logic [FLAG_W-1:0]  flag_set, flag_clr, flag_q;
    logic [FLAG_W-1:0]  en_set, en_clr, en_q;
    reg_addr_e          addr;

    assign addr = reg_addr_e'(bus_addr);

    rtc_prescaler #(.W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (presc)
    );

    rtc_edge_detect #(.W(PRESC_W), .NUM(NUM_PER), .OFS(PER_OFS)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .presc (presc),
        .rise  (per_rise)
    );

    // Gather the hardware set requests into the flag word positions.
    always_comb begin
        flag_set = '0;
        flag_set[BIT_OVF]    = ovf_evt;
        flag_set[BIT_TAMPER] = tamper_evt;
        flag_set[BIT_ALARM0 +: NUM_ALARM] = alarm_evt;
        flag_set[NUM_PER-1:0] = per_rise;
    end

    // Decode the bus writes into flag clears and enable set and clear vectors.
    always_comb begin
        flag_clr = '0;
        en_set   = '0;
        en_clr   = '0;
        if (bus_wr) begin
            unique case (addr)
                ADDR_FLAGS:  flag_clr = bus_wdata;
                ADDR_EN_SET: en_set   = bus_wdata;
                ADDR_EN_CLR: en_clr   = bus_wdata;
                default: ;
            endcase
        end
    end

    rtc_flag_bank #(.W(FLAG_W), .MASK(IMPL_MASK)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .q     (flag_q)
    );

    rtc_flag_bank #(.W(FLAG_W), .MASK(IMPL_MASK)) u_enables (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (en_set),
        .clr   (en_clr),
        .q     (en_q)
    );

    // Select the read data for the current address.
    always_comb begin
        unique case (addr)
            ADDR_FLAGS:               bus_rdata = flag_q;
            ADDR_EN_SET, ADDR_EN_CLR: bus_rdata = en_q;
            default:                  bus_rdata = '0;
        endcase
    end

    assign irq = |(flag_q & en_q);
endmodule

// File: rtl/rtc_irq_ctrl_sva.sv
// Module: assertion checker for rtc_irq_ctrl. It is attached to the top module with bind
// and reads the top module's ports and its registered flag and enable words.
module rtc_irq_ctrl_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        ovf_evt,
    input logic        tamper_evt,
    input logic [1:0]  alarm_evt,
    input logic        irq,
    input logic [15:0] flags,
    input logic [15:0] en
);
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (flags == 16'h0 && en == 16'h0));
    p_unimpl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 2'd3) |-> (bus_rdata[13:10] == 4'h0));
    p_addr3_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == 16'h0));
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[15] && !ovf_evt) |=> !flags[15]);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[14] && !(bus_wr && bus_addr == 2'd0 && bus_wdata[14])) |=> flags[14]);
    p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n) ovf_evt |=> flags[15]);
    p_alarm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt[1] |=> flags[9]);
    p_tamper_set_r6: assert property (@(posedge clk) disable iff (!rst_n) tamper_evt |=> flags[14]);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt[0] && bus_wr && bus_addr == 2'd0 && bus_wdata[8]) |=> flags[8]);
    p_en_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[0]) |=> en[0]);
    p_en_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && bus_wdata[15]) |=> !en[15]);
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 16'h0 && en != 16'h0));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ovf_evt    (ovf_evt),
    .tamper_evt (tamper_evt),
    .alarm_evt  (alarm_evt),
    .irq        (irq),
    .flags      (flag_q),
    .en         (en_q)
);

// File: tb/rtc_irq_ctrl_test.sv
`timescale 1ns/1ps
// Bench: a behavioural model is stepped on every rising edge, and rdata and irq are
// compared against it on every falling edge.
module rtc_irq_ctrl_test;
    localparam int PW = 10;
    localparam logic [15:0] MASK = 16'hC3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ovf_evt = 1'b0;
    logic        tamper_evt = 1'b0;
    logic [1:0]  alarm_evt = 2'b00;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    string tag = "R1";

    // model state
    int          m_presc = 0;
    int          m_prev  = 0;
    logic [15:0] m_flags = 16'h0;
    logic [15:0] m_en    = 16'h0;

    rtc_irq_ctrl #(.PRESC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_evt(ovf_evt),
        .tamper_evt(tamper_evt), .alarm_evt(alarm_evt), .irq(irq)
    );

    always #2 clk = ~clk;

    // Reference model: advance one clock.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_presc = 0; m_prev = 0; m_flags = 16'h0; m_en = 16'h0;
        end else begin
            logic [15:0] s, c;
            s = 16'h0;
            c = 16'h0;
            if (ovf_evt)      s[15] = 1'b1;
            if (tamper_evt)   s[14] = 1'b1;
            if (alarm_evt[0]) s[8]  = 1'b1;
            if (alarm_evt[1]) s[9]  = 1'b1;
            for (int n = 0; n < 8; n++)
                if (((m_presc >> (n+2)) & 1) == 1 && ((m_prev >> (n+2)) & 1) == 0) s[n] = 1'b1;
            if (bus_wr && bus_addr == 2'd0) c = bus_wdata;
            m_flags = ((m_flags & ~c) | s) & MASK;
            if (bus_wr && bus_addr == 2'd1) m_en = (m_en | bus_wdata) & MASK;
            if (bus_wr && bus_addr == 2'd2) m_en = m_en & ~bus_wdata;
            m_prev  = m_presc;
            m_prev  = m_prev;
            m_presc = (m_presc + 1) % (1 << PW);
        end
    end

    // Compare every falling edge while out of reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] exp_rd;
            logic        exp_irq;
            exp_rd = (bus_addr == 2'd0) ? m_flags :
                     (bus_addr == 2'd3) ? 16'h0 : m_en;
            exp_irq = |(m_flags & m_en);
            tests++;
            if (bus_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s rdata addr=%0d actual=%h expected=%h t=%0t",
                         tag, bus_addr, bus_rdata, exp_rd, $time);
            end
            tests++;
            if (irq !== exp_irq) begin
                fails++;
                $display("FAIL R10 (%s) irq actual=%b expected=%b t=%0t",
                         tag, irq, exp_irq, $time);
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset state is seen on the following compares
        tag = "R1"; bus_addr = 2'd0; cyc();
        bus_addr = 2'd1; cyc();
        // R9: enable set and clear strobes
        tag = "R9";
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'h00F0);
        wr(2'd1, 16'h0000);
        bus_addr = 2'd2; idle(2);
        wr(2'd2, 16'h0000);
        bus_addr = 2'd0;
        // R5: overflow and alarms
        tag = "R5";
        ovf_evt = 1'b1; cyc(); ovf_evt = 1'b0; idle(2);
        alarm_evt = 2'b01; cyc(); alarm_evt = 2'b10; cyc(); alarm_evt = 2'b00; idle(2);
        // R6: tamper
        tag = "R6";
        tamper_evt = 1'b1; cyc(); tamper_evt = 1'b0; idle(2);
        // R4: write-one-to-clear
        tag = "R4";
        wr(2'd0, 16'h0000); idle(1);
        wr(2'd0, 16'h8000); idle(1);
        wr(2'd0, 16'h4100); idle(1);
        wr(2'd0, 16'hFFFF); idle(1);
        // R3: unimplemented bits
        tag = "R3";
        alarm_evt = 2'b11; cyc(); alarm_evt = 2'b00;
        wr(2'd0, 16'h3C00); idle(1);
        wr(2'd1, 16'h3C00); bus_addr = 2'd1; idle(2);
        wr(2'd2, 16'h3C00); bus_addr = 2'd0;
        // R8: set wins over clear
        tag = "R8";
        ovf_evt = 1'b1; alarm_evt = 2'b01;
        wr(2'd0, 16'h8100);
        ovf_evt = 1'b0; alarm_evt = 2'b00; idle(2);
        wr(2'd0, 16'hFFFF);
        tamper_evt = 1'b1; wr(2'd0, 16'h4000); tamper_evt = 1'b0; idle(2);
        // R10: irq follows flags and enables
        tag = "R10";
        wr(2'd2, 16'hFFFF); wr(2'd0, 16'hFFFF);
        ovf_evt = 1'b1; cyc(); ovf_evt = 1'b0; idle(3);
        wr(2'd1, 16'h8000); idle(2);
        wr(2'd0, 16'h8000); idle(2);
        wr(2'd1, 16'h0001); idle(12);
        // R2: address 3 reads zero and ignores writes
        tag = "R2";
        wr(2'd3, 16'hFFFF); bus_addr = 2'd3; idle(2);
        bus_addr = 2'd0; idle(2);
        // R7: periodic flags over more than two prescaler wraps
        tag = "R7";
        wr(2'd1, 16'h00FF);
        for (int k = 0; k < 70; k++) begin
            idle(36);
            wr(2'd0, 16'h00FF);
        end
        idle(40);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule